// File: doc/BRIEF.md
# Out-of-Order Issue Queue with Tag Wakeup and Age-Ordered Select

This block parks renamed operations until both of their source operands exist, then hands them to execution ports. Each slot records two source physical tags with one ready flag each, a destination tag, the execution port it is bound to, and a sequence number that gives its age. Results finishing anywhere in the machine are announced on broadcast lanes as destination tags. Every waiting source that compares equal to a valid lane sets its ready flag. Readiness depends only on the result being produced; it does not wait for the producer to retire.

On each cycle a picker for each port looks at the slots that are fully ready, bound to that port, and not blocked by a busy port. It grants the oldest one. The granted operation is driven on the port's issue outputs in that same cycle and its slot is released at the clock edge. The operation then begins execution in the following cycle. Rename pushes operations through a valid/ready handshake. The ready output drops when every slot is occupied, and also while a flush is applied. A flush removes every waiting operation that is younger than a given sequence number.

Sequence numbers wrap around. The block orders two numbers by the sign of their modular difference, so upstream must keep all live operations within half the sequence space of each other.

Top module: `rs_issue_queue`

## Requirements
- R1: After reset no issue output is valid and `ins_ready` is high.
- R2: A source whose ready flag is set at insertion needs no broadcast; an operation inserted with both flags set and a free port is issued in the next cycle.
- R3: An operation is never issued while either source is waiting; a source waits until a valid broadcast lane carries its tag.
- R4: A broadcast in cycle N that completes an operation's sources lets it be issued in cycle N+1, not in cycle N.
- R5: When several ready operations are bound to one port, the one with the oldest sequence number is issued first.
- R6: An issued operation leaves the queue at the clock edge after its issue cycle and is never issued again.
- R7: A broadcast in the same cycle as an insertion is compared against the incoming sources, so a match counts as ready.
- R8: With all DEPTH slots occupied `ins_ready` is low, and an insertion offered then is not taken.
- R9: In a cycle with `flush_valid` high, every operation strictly younger than `flush_seq` is dropped and cannot issue in that cycle. Operations the same age or older are kept. `ins_ready` is low in that cycle.
- R10: A port whose `port_busy` bit is high issues nothing in that cycle, and its ready operations stay queued.
- R11: Age comparisons are modular: sequence number a is older than b when bit SEQ_W-1 of (a - b) is set. Ordering stays correct across wrap as long as live operations span less than half the sequence space.
- R12: Port p's issue slice (bits p*TAG_W upward, or p*SEQ_W for the sequence) carries the destination, both source tags and the sequence number of the granted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Rename offers an operation |
| ins_ready | output | 1 | Queue accepts the offered operation |
| ins_src_a | input | TAG_W | First source physical tag |
| ins_src_a_rdy | input | 1 | First source already available |
| ins_src_b | input | TAG_W | Second source physical tag |
| ins_src_b_rdy | input | 1 | Second source already available |
| ins_dst | input | TAG_W | Destination physical tag |
| ins_port | input | PORT_W | Execution port the operation is bound to |
| ins_seq | input | SEQ_W | Sequence number (age) of the operation |
| bc_valid | input | NBC | Valid bit per broadcast lane |
| bc_tag | input | NBC*TAG_W | Tag per broadcast lane, lane k at bits k*TAG_W |
| port_busy | input | NPORTS | Port cannot accept an operation this cycle |
| iss_valid | output | NPORTS | Operation issued on the port |
| iss_dst | output | NPORTS*TAG_W | Destination tag per port |
| iss_src_a | output | NPORTS*TAG_W | First source tag per port |
| iss_src_b | output | NPORTS*TAG_W | Second source tag per port |
| iss_seq | output | NPORTS*SEQ_W | Sequence number per port |
| flush_valid | input | 1 | Drop operations younger than flush_seq |
| flush_seq | input | SEQ_W | Flush boundary sequence number |

## Verification
The hardest condition to reach from the ports is age ordering across wrap while slots are reused out of order. That needs a queue whose live sequence numbers straddle zero, with freed slots refilled by younger operations in low-numbered positions. The stimulus reaches it with a long random run over a small tag space, so wakeups happen often. It throttles insertion only to keep the live span under half the sequence space, and it mixes in busy ports and flushes that rewind the sequence counter. Directed phases first pin down wakeup timing, same-cycle insert matching, the full stall and the flush boundary.

// File: rtl/rs_pkg.sv
package rs_pkg;
    parameter int RS_TAG_W = 6;
    parameter int RS_SEQ_W = 5;

    typedef logic [RS_TAG_W-1:0] tag_t;
    typedef logic [RS_SEQ_W-1:0] seq_t;

    // a is older than b when the modular difference is negative
    function automatic logic seq_before(seq_t a, seq_t b);
        seq_t diff;
        diff = a - b;
        return diff[RS_SEQ_W-1];
    endfunction
endpackage

// File: rtl/rs_tag_match.sv
module rs_tag_match
    import rs_pkg::*;
#(
    parameter int NBC = 2
) (
    input  tag_t                  tag,
    input  logic [NBC-1:0]        bc_valid,
    input  logic [NBC*RS_TAG_W-1:0] bc_tag,
    output logic                  hit
);
    always_comb begin
        hit = 1'b0;
        for (int k = 0; k < NBC; k++) begin
            if (bc_valid[k] && (bc_tag[k*RS_TAG_W +: RS_TAG_W] == tag)) begin
                hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rs_pick_oldest.sv
module rs_pick_oldest
    import rs_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic [DEPTH-1:0]          req,
    input  logic [DEPTH*RS_SEQ_W-1:0] seqs,
    output logic [DEPTH-1:0]          gnt
);
    logic found;
    int   best;
    seq_t best_seq;

    always_comb begin
        found    = 1'b0;
        best     = 0;
        best_seq = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (req[i] && (!found || seq_before(seqs[i*RS_SEQ_W +: RS_SEQ_W], best_seq))) begin
                found    = 1'b1;
                best     = i;
                best_seq = seqs[i*RS_SEQ_W +: RS_SEQ_W];
            end
        end
        gnt = '0;
        if (found) begin
            gnt[best] = 1'b1;
        end
    end
endmodule

// File: rtl/rs_first_free.sv
module rs_first_free #(
    parameter int DEPTH = 8
) (
    input  logic [DEPTH-1:0] used,
    output logic [DEPTH-1:0] slot,
    output logic             full
);
    logic seen;

    always_comb begin
        slot = '0;
        seen = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!used[i] && !seen) begin
                slot[i] = 1'b1;
                seen    = 1'b1;
            end
        end
        full = !seen;
    end
endmodule

// File: rtl/rs_issue_queue.sv
module rs_issue_queue
    import rs_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int NPORTS = 2,
    parameter int NBC    = 2,
    localparam int PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ins_valid,
    output logic                       ins_ready,
    input  logic [RS_TAG_W-1:0]        ins_src_a,
    input  logic                       ins_src_a_rdy,
    input  logic [RS_TAG_W-1:0]        ins_src_b,
    input  logic                       ins_src_b_rdy,
    input  logic [RS_TAG_W-1:0]        ins_dst,
    input  logic [PORT_W-1:0]          ins_port,
    input  logic [RS_SEQ_W-1:0]        ins_seq,
    input  logic [NBC-1:0]             bc_valid,
    input  logic [NBC*RS_TAG_W-1:0]    bc_tag,
    input  logic [NPORTS-1:0]          port_busy,
    output logic [NPORTS-1:0]          iss_valid,
    output logic [NPORTS*RS_TAG_W-1:0] iss_dst,
    output logic [NPORTS*RS_TAG_W-1:0] iss_src_a,
    output logic [NPORTS*RS_TAG_W-1:0] iss_src_b,
    output logic [NPORTS*RS_SEQ_W-1:0] iss_seq,
    input  logic                       flush_valid,
    input  logic [RS_SEQ_W-1:0]        flush_seq
);
    typedef struct packed {
        logic              vld;
        tag_t              src_a;
        logic              rdy_a;
        tag_t              src_b;
        logic              rdy_b;
        tag_t              dst;
        seq_t              seq;
        logic [PORT_W-1:0] port;
    } entry_t;

    typedef struct packed {
        entry_t [DEPTH-1:0] ent;
    } state_t;

    state_t st_d, st_q;

    logic [DEPTH-1:0]          valid_vec;
    logic [DEPTH-1:0]          both_rdy_vec;
    logic [DEPTH-1:0]          hit_a, hit_b;
    logic [DEPTH-1:0]          eligible;
    logic [DEPTH-1:0]          slot;
    logic [DEPTH*RS_SEQ_W-1:0] seq_flat;
    logic [NPORTS*DEPTH-1:0]   req_flat;
    logic [NPORTS*DEPTH-1:0]   gnt_flat;
    logic                      full;
    logic                      ins_hit_a, ins_hit_b;

    // per-slot views and wakeup comparators
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        assign valid_vec[i]    = st_q.ent[i].vld;
        assign both_rdy_vec[i] = st_q.ent[i].rdy_a & st_q.ent[i].rdy_b;
        assign seq_flat[i*RS_SEQ_W +: RS_SEQ_W] = st_q.ent[i].seq;

        rs_tag_match #(.NBC(NBC)) u_wake_a (
            .tag(st_q.ent[i].src_a), .bc_valid(bc_valid), .bc_tag(bc_tag), .hit(hit_a[i])
        );
        rs_tag_match #(.NBC(NBC)) u_wake_b (
            .tag(st_q.ent[i].src_b), .bc_valid(bc_valid), .bc_tag(bc_tag), .hit(hit_b[i])
        );
    end

    // incoming operation sees this cycle's broadcasts too
    rs_tag_match #(.NBC(NBC)) u_ins_a (
        .tag(ins_src_a), .bc_valid(bc_valid), .bc_tag(bc_tag), .hit(ins_hit_a)
    );
    rs_tag_match #(.NBC(NBC)) u_ins_b (
        .tag(ins_src_b), .bc_valid(bc_valid), .bc_tag(bc_tag), .hit(ins_hit_b)
    );

    rs_first_free #(.DEPTH(DEPTH)) u_free (
        .used(valid_vec), .slot(slot), .full(full)
    );

    assign ins_ready = !full && !flush_valid;

    // request matrix: registered readiness only, so wakeup takes one edge
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            eligible[i] = valid_vec[i] && both_rdy_vec[i] &&
                          !(flush_valid && seq_before(flush_seq, st_q.ent[i].seq));
        end
        for (int p = 0; p < NPORTS; p++) begin
            for (int i = 0; i < DEPTH; i++) begin
                req_flat[p*DEPTH + i] = eligible[i] && !port_busy[p] &&
                                        (st_q.ent[i].port == PORT_W'(p));
            end
        end
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        rs_pick_oldest #(.DEPTH(DEPTH)) u_pick (
            .req(req_flat[p*DEPTH +: DEPTH]),
            .seqs(seq_flat),
            .gnt(gnt_flat[p*DEPTH +: DEPTH])
        );
    end

    // issue outputs: AND-OR mux on one-hot grants
    always_comb begin
        iss_valid = '0;
        iss_dst   = '0;
        iss_src_a = '0;
        iss_src_b = '0;
        iss_seq   = '0;
        for (int p = 0; p < NPORTS; p++) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (gnt_flat[p*DEPTH + i]) begin
                    iss_valid[p]                         = 1'b1;
                    iss_dst[p*RS_TAG_W +: RS_TAG_W]      = st_q.ent[i].dst;
                    iss_src_a[p*RS_TAG_W +: RS_TAG_W]    = st_q.ent[i].src_a;
                    iss_src_b[p*RS_TAG_W +: RS_TAG_W]    = st_q.ent[i].src_b;
                    iss_seq[p*RS_SEQ_W +: RS_SEQ_W]      = st_q.ent[i].seq;
                end
            end
        end
    end

    // next state
    always_comb begin
        logic taken;
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            taken = 1'b0;
            for (int p = 0; p < NPORTS; p++) begin
                taken = taken | gnt_flat[p*DEPTH + i];
            end
            if (taken || (flush_valid && seq_before(flush_seq, st_q.ent[i].seq))) begin
                st_d.ent[i].vld = 1'b0;
            end
            if (hit_a[i]) st_d.ent[i].rdy_a = 1'b1;
            if (hit_b[i]) st_d.ent[i].rdy_b = 1'b1;
        end
        if (ins_valid && ins_ready) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (slot[i]) begin
                    st_d.ent[i].vld   = 1'b1;
                    st_d.ent[i].src_a = ins_src_a;
                    st_d.ent[i].rdy_a = ins_src_a_rdy | ins_hit_a;
                    st_d.ent[i].src_b = ins_src_b;
                    st_d.ent[i].rdy_b = ins_src_b_rdy | ins_hit_b;
                    st_d.ent[i].dst   = ins_dst;
                    st_d.ent[i].seq   = ins_seq;
                    st_d.ent[i].port  = ins_port;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rs_issue_queue_chk.sv
module rs_issue_queue_chk #(
    parameter int DEPTH  = 8,
    parameter int NPORTS = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     flush_valid,
    input logic                     ins_ready,
    input logic [NPORTS-1:0]        port_busy,
    input logic [NPORTS-1:0]        iss_valid,
    input logic [DEPTH-1:0]         valid_vec,
    input logic [DEPTH-1:0]         both_rdy_vec,
    input logic [NPORTS*DEPTH-1:0]  gnt_flat
);
    a_r8_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(valid_vec) == DEPTH) |-> !ins_ready);

    a_r9_flush_blocks_insert: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> !ins_ready);

    for (genvar p = 0; p < NPORTS; p++) begin : g_p
        a_r10_busy_port_idle: assert property (@(posedge clk) disable iff (!rst_n)
            port_busy[p] |-> !iss_valid[p]);

        a_r5_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(gnt_flat[p*DEPTH +: DEPTH]));

        for (genvar i = 0; i < DEPTH; i++) begin : g_i
            a_r3_grant_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
                gnt_flat[p*DEPTH + i] |-> (valid_vec[i] && both_rdy_vec[i]));

            a_r6_slot_released: assert property (@(posedge clk) disable iff (!rst_n)
                gnt_flat[p*DEPTH + i] |=> !valid_vec[i]);
        end
    end
endmodule

bind rs_issue_queue rs_issue_queue_chk #(.DEPTH(DEPTH), .NPORTS(NPORTS)) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .flush_valid(flush_valid),
    .ins_ready(ins_ready),
    .port_busy(port_busy),
    .iss_valid(iss_valid),
    .valid_vec(valid_vec),
    .both_rdy_vec(both_rdy_vec),
    .gnt_flat(gnt_flat)
);

// File: tb/sim_rs_issue_queue.sv
`timescale 1ns/1ps
module sim_rs_issue_queue;
    localparam int DEPTH = 8;
    localparam int NP    = 2;
    localparam int NBC   = 2;
    localparam int TW    = 6;
    localparam int SW    = 5;
    localparam int SMASK = (1 << SW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ins_valid, ins_ready, ins_src_a_rdy, ins_src_b_rdy;
    logic [TW-1:0] ins_src_a, ins_src_b, ins_dst;
    logic [0:0] ins_port;
    logic [SW-1:0] ins_seq;
    logic [NBC-1:0] bc_valid;
    logic [NBC*TW-1:0] bc_tag;
    logic [NP-1:0] port_busy, iss_valid;
    logic [NP*TW-1:0] iss_dst, iss_src_a, iss_src_b;
    logic [NP*SW-1:0] iss_seq;
    logic flush_valid;
    logic [SW-1:0] flush_seq;

    always #10 clk = ~clk;

    rs_issue_queue #(.DEPTH(DEPTH), .NPORTS(NP), .NBC(NBC)) u0 (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_ready(ins_ready),
        .ins_src_a(ins_src_a), .ins_src_a_rdy(ins_src_a_rdy),
        .ins_src_b(ins_src_b), .ins_src_b_rdy(ins_src_b_rdy),
        .ins_dst(ins_dst), .ins_port(ins_port), .ins_seq(ins_seq),
        .bc_valid(bc_valid), .bc_tag(bc_tag),
        .port_busy(port_busy), .iss_valid(iss_valid),
        .iss_dst(iss_dst), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
        .iss_seq(iss_seq),
        .flush_valid(flush_valid), .flush_seq(flush_seq)
    );

    typedef struct {
        int sa; bit ra; int sb; bit rb; int dst; int seq; int port;
    } ment_t;

    ment_t mq[$];
    int nchk = 0;
    int nfail = 0;
    int next_seq = 0;

    task automatic chk(string tag, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic bit younger(int e, int f);
        int d;
        d = (e - f) & SMASK;
        return (d != 0) && (d < (1 << (SW - 1)));
    endfunction

    function automatic bit bc_hit(int t);
        for (int k = 0; k < NBC; k++)
            if (bc_valid[k] && int'(bc_tag[k*TW +: TW]) == t) return 1'b1;
        return 1'b0;
    endfunction

    task automatic set_idle();
        ins_valid = 0; ins_src_a = '0; ins_src_a_rdy = 0; ins_src_b = '0;
        ins_src_b_rdy = 0; ins_dst = '0; ins_port = '0; ins_seq = '0;
        bc_valid = '0; bc_tag = '0; port_busy = '0;
        flush_valid = 0; flush_seq = '0;
    endtask

    task automatic set_ins(int sa, bit ra, int sb, bit rb, int dst, int port);
        ins_valid = 1;
        ins_src_a = TW'(sa); ins_src_a_rdy = ra;
        ins_src_b = TW'(sb); ins_src_b_rdy = rb;
        ins_dst = TW'(dst); ins_port = 1'(port); ins_seq = SW'(next_seq);
    endtask

    // compare this cycle against the model, then advance the model one edge
    task automatic step(string tag);
        bit exp_ready;
        int pick[NP];
        ment_t nq[$];
        ment_t e;
        #1;
        exp_ready = (mq.size() < DEPTH) && !flush_valid;
        chk(tag, "ins_ready", int'(ins_ready), int'(exp_ready));
        for (int p = 0; p < NP; p++) begin
            pick[p] = -1;
            if (!port_busy[p]) begin
                for (int k = 0; k < mq.size(); k++) begin
                    if (pick[p] < 0 && mq[k].port == p && mq[k].ra && mq[k].rb &&
                        !(flush_valid && younger(mq[k].seq, int'(flush_seq))))
                        pick[p] = k;
                end
            end
            chk(tag, $sformatf("iss_valid[%0d]", p), int'(iss_valid[p]), int'(pick[p] >= 0));
            if (pick[p] >= 0 && iss_valid[p]) begin
                chk("R12", "iss_dst", int'(iss_dst[p*TW +: TW]), mq[pick[p]].dst);
                chk("R12", "iss_seq", int'(iss_seq[p*SW +: SW]), mq[pick[p]].seq);
                chk("R12", "iss_src_a", int'(iss_src_a[p*TW +: TW]), mq[pick[p]].sa);
                chk("R12", "iss_src_b", int'(iss_src_b[p*TW +: TW]), mq[pick[p]].sb);
            end
        end
        for (int k = 0; k < mq.size(); k++) begin
            bit drop;
            drop = flush_valid && younger(mq[k].seq, int'(flush_seq));
            for (int p = 0; p < NP; p++) if (pick[p] == k) drop = 1'b1;
            if (!drop) begin
                e = mq[k];
                if (bc_hit(e.sa)) e.ra = 1'b1;
                if (bc_hit(e.sb)) e.rb = 1'b1;
                nq.push_back(e);
            end
        end
        if (ins_valid && exp_ready) begin
            e.sa = int'(ins_src_a); e.ra = ins_src_a_rdy | bc_hit(int'(ins_src_a));
            e.sb = int'(ins_src_b); e.rb = ins_src_b_rdy | bc_hit(int'(ins_src_b));
            e.dst = int'(ins_dst); e.seq = int'(ins_seq); e.port = int'(ins_port);
            nq.push_back(e);
            next_seq = (next_seq + 1) & SMASK;
        end
        if (flush_valid) next_seq = (int'(flush_seq) + 1) & SMASK;
        mq = nq;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        set_idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        step("R1");

        // R2 ready at insertion
        set_ins(1, 1, 2, 1, 10, 0); step("R2");
        set_idle(); step("R2"); step("R6");

        // R3 waiting source, R4 wakeup timing
        set_ins(5, 0, 6, 1, 11, 1); step("R3");
        set_idle(); repeat (3) step("R3");
        bc_valid = 2'b01; bc_tag = {6'd0, 6'd5}; step("R4");
        set_idle(); step("R4"); step("R6");

        // R7 broadcast in the insertion cycle
        set_ins(9, 0, 9, 0, 12, 0); bc_valid = 2'b10; bc_tag = {6'd9, 6'd0};
        step("R7");
        set_idle(); step("R7");

        // R10 busy port, then R5 oldest first
        port_busy = 2'b01;
        for (int j = 0; j < 3; j++) begin
            set_ins(3, 1, 4, 1, 20 + j, 0); port_busy = 2'b01; step("R10");
        end
        set_idle(); port_busy = 2'b01; repeat (2) step("R10");
        set_idle(); repeat (4) step("R5");

        // R8 fill to full with both ports busy
        for (int j = 0; j < 10; j++) begin
            set_ins(7, 1, 8, j % 2 == 0, 30 + j, j % 2); port_busy = 2'b11; step("R8");
        end

        // R9 flush with an insertion offered at the same time
        set_ins(1, 1, 1, 1, 40, 0); port_busy = 2'b11;
        flush_valid = 1; flush_seq = SW'((next_seq - 4) & SMASK); step("R9");
        set_idle(); bc_valid = 2'b01; bc_tag = {6'd0, 6'd8}; step("R9");
        set_idle(); repeat (8) step("R9");

        // R11 long random run across many sequence wraps
        for (int c = 0; c < 4000; c++) begin
            set_idle();
            if ($urandom % 10 < 6) begin
                set_ins($urandom % 16, $urandom % 2, $urandom % 16, $urandom % 2,
                        $urandom % 64, $urandom % 2);
                if (mq.size() > 0 && ((next_seq - mq[0].seq) & SMASK) >= 14) ins_valid = 0;
            end
            bc_valid = 2'($urandom);
            bc_tag = {6'($urandom % 16), 6'($urandom % 16)};
            port_busy = {($urandom % 5) == 0, ($urandom % 5) == 0};
            if ($urandom % 50 == 0) begin
                flush_valid = 1;
                flush_seq = SW'((next_seq - 1 - int'($urandom % 6)) & SMASK);
            end
            step("R11");
        end

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule